// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous single-word request port to an external asynchronous static RAM. The RAM has 16-bit words, a 16-bit address, active-low chip, output and write enables, and one active-low enable per byte lane. A requester presents a read/write flag, an address, write data and a byte mask, all qualified by a valid strobe. The controller then plays out a timed pin sequence. Read data comes back with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. Each length is derived from the clock period and the memory's nanosecond minimums, and is rounded up. Reads hold the output enable low for the access window and sample the bus at its end. Writes hold the write strobe low for the pulse window. Each write then ends by raising only the write enable, while chip enable, the byte enables, the address and the data stay put for one more cycle. Every access is followed by a bus-turnaround gap with the chip deselected. While the block is idle, chip enable is high and the memory rests in standby. The data bus is split into separate out, in and drive-enable signals for the pad ring.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, req_ready is 1, rsp_valid is 0, mem_ce_n, mem_oe_n and mem_we_n are 1, all mem_be_n bits are 1 and mem_dq_oe is 0.
- R2: A request is taken only at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after that edge until the sequence completes: RD_CYC+TA_CYC cycles for a read, WR_CYC+1+TA_CYC cycles for a write, and 1 cycle for a no-op.
- R3: For RD_CYC cycles after a read is taken, mem_ce_n=0, mem_oe_n=0, mem_we_n=1, mem_addr equals the request address, and mem_be_n equals the inverted mask. Mask bit 0 is the lane for bits 7:0, and mask bit 1 is the lane for bits 15:8.
- R4: In the cycle after the read window, rsp_valid is 1 for exactly one cycle. rsp_rdata carries the bus value sampled at the end of the window, with the lanes whose mask bit is 0 forced to zero.
- R5: For WR_CYC cycles after a write is taken, mem_ce_n=0, mem_we_n=0, mem_oe_n=1, mem_be_n equals the inverted mask, mem_dq_out equals the write data and mem_dq_oe=1.
- R6: A write ends with one cycle in which mem_we_n is 1 while mem_ce_n, mem_be_n, mem_addr and mem_dq_out stay unchanged. After that cycle all strobes are released and mem_dq_oe returns to 0.
- R7: mem_dq_oe is 1 only during a write sequence and is never 1 while mem_oe_n is 0.
- R8: Each read or write is followed by TA_CYC cycles with mem_ce_n=1 and req_ready=0.
- R9: RD_CYC, WR_CYC and TA_CYC are the nanosecond minimums divided by CLK_NS and rounded up (minimum 1). At the defaults (4 ns clock) they are 3, 2 and 2.
- R10: A request whose mask is zero changes no memory pin. It brings req_ready back after one cycle. If it is a read, it still gives a one-cycle rsp_valid with rsp_rdata equal to zero.
- R11: Request inputs that are presented while req_ready is 0 are ignored: mem_addr and mem_dq_out keep the accepted values, and no extra response appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane mask, bit 0 = bits 7:0 |
| req_ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low, bit 0 = lower byte |
| mem_dq_out | output | DATA_W | Data driven to the bus |
| mem_dq_in | input | DATA_W | Data received from the bus |
| mem_dq_oe | output | 1 | Bus drive enable for the pad |

## Verification
Take the acceptance edge as edge k. The read strobes appear in the cycle after edge k and last RD_CYC cycles, and rsp_valid is due just after edge k+RD_CYC. For a write, the write-enable rise is due after edge k+WR_CYC and the release after edge k+WR_CYC+1. req_ready returns TA_CYC cycles after the release, and one cycle after a no-op. Each transaction in the bench steps one falling edge at a time from the acceptance edge. At each step it compares every pin against the value due at that step. Expected read data comes from a shadow array that the bench updates only from the requests it issued.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_HOLD,
    ST_TURN,
    ST_NOP
  } seq_state_t;

  // Nanoseconds to whole cycles, rounded up, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 3,
  parameter int WR_CYC = 2,
  parameter int TA_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_empty,
  output logic ready,
  output logic start_rd,
  output logic start_wr,
  output logic start_nop,
  output logic wr_lift,
  output logic rd_cap,
  output logic wr_rel
);

  localparam int MAXC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ready_q;
  logic accept;

  assign accept    = req_valid && ready_q;
  assign start_nop = accept && req_empty;
  assign start_rd  = accept && !req_empty && !req_write;
  assign start_wr  = accept && !req_empty && req_write;
  assign rd_cap    = (state_q == ST_READ)  && (cnt_q == '0);
  assign wr_lift   = (state_q == ST_WRITE) && (cnt_q == '0);
  assign wr_rel    = (state_q == ST_HOLD);
  assign ready     = ready_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rd) begin
          state_d = ST_READ;
          cnt_d   = CW'(RD_CYC - 1);
        end else if (start_wr) begin
          state_d = ST_WRITE;
          cnt_d   = CW'(WR_CYC - 1);
        end else if (start_nop) begin
          state_d = ST_NOP;
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          state_d = ST_TURN;
          cnt_d   = CW'(TA_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt_q == '0) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        state_d = ST_TURN;
        cnt_d   = CW'(TA_CYC - 1);
      end
      ST_TURN: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_NOP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ready_q <= (state_d == ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              wr_lift,
  input  logic              release_all,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_n_q,
  output logic              oe_n_q,
  output logic              we_n_q,
  output logic [LANES-1:0]  be_n_q,
  output logic [DATA_W-1:0] dq_out_q,
  output logic              dq_oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      be_n_q   <= '1;
      dq_out_q <= '0;
      dq_oe_q  <= 1'b0;
    end else if (start_rd) begin
      addr_q <= req_addr;
      ce_n_q <= 1'b0;
      oe_n_q <= 1'b0;
      be_n_q <= ~req_mask;
    end else if (start_wr) begin
      addr_q   <= req_addr;
      ce_n_q   <= 1'b0;
      we_n_q   <= 1'b0;
      be_n_q   <= ~req_mask;
      dq_out_q <= req_wdata;
      dq_oe_q  <= 1'b1;
    end else if (wr_lift) begin
      // only the write strobe moves; the rest is held for data/address hold
      we_n_q <= 1'b1;
    end else if (release_all) begin
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      be_n_q  <= '1;
      dq_oe_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cap,
  input  logic              nop_rd,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_cap || nop_rd;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[l*8 +: 8] <= '0;
      end else if (rd_cap) begin
        data_q[l*8 +: 8] <= be_n[l] ? 8'h00 : dq_in[l*8 +: 8];
      end else if (nop_rd) begin
        data_q[l*8 +: 8] <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 16,
  parameter int CLK_NS         = 4,
  parameter int T_CYCLE_NS     = 10,
  parameter int T_ACCESS_NS    = 10,
  parameter int T_OE_DATA_NS   = 5,
  parameter int T_WE_PULSE_NS  = 7,
  parameter int T_ADDR_WEND_NS = 8,
  parameter int T_DATA_WEND_NS = 5,
  parameter int T_BYTE_WEND_NS = 7,
  parameter int T_RELEASE_NS   = 5,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int RD_CYC = max2(ns_to_cyc(max2(T_ACCESS_NS, T_OE_DATA_NS), CLK_NS),
                               ns_to_cyc(T_CYCLE_NS, CLK_NS));
  localparam int WR_MIN = max2(max2(ns_to_cyc(T_WE_PULSE_NS, CLK_NS), ns_to_cyc(T_ADDR_WEND_NS, CLK_NS)),
                               max2(ns_to_cyc(T_DATA_WEND_NS, CLK_NS), ns_to_cyc(T_BYTE_WEND_NS, CLK_NS)));
  // the hold cycle counts toward the whole write cycle
  localparam int WR_CYC = max2(WR_MIN, ns_to_cyc(T_CYCLE_NS, CLK_NS) - 1);
  localparam int TA_CYC = ns_to_cyc(T_RELEASE_NS, CLK_NS);

  logic start_rd, start_wr, start_nop, wr_lift, rd_cap, wr_rel;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC),
    .WR_CYC(WR_CYC),
    .TA_CYC(TA_CYC)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_empty(req_mask == '0),
    .ready    (req_ready),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .start_nop(start_nop),
    .wr_lift  (wr_lift),
    .rd_cap   (rd_cap),
    .wr_rel   (wr_rel)
  );

  sram_pin_drv #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) i_pins (
    .clk        (clk),
    .rst        (rst),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .wr_lift    (wr_lift),
    .release_all(rd_cap || wr_rel),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .addr_q     (mem_addr),
    .ce_n_q     (mem_ce_n),
    .oe_n_q     (mem_oe_n),
    .we_n_q     (mem_we_n),
    .be_n_q     (mem_be_n),
    .dq_out_q   (mem_dq_out),
    .dq_oe_q    (mem_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) i_cap (
    .clk    (clk),
    .rst    (rst),
    .rd_cap (rd_cap),
    .nop_rd (start_nop && !req_write),
    .be_n   (mem_be_n),
    .dq_in  (mem_dq_in),
    .valid_q(rsp_valid),
    .data_q (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WR_CYC = 2,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  we_low_cnt <= '0;
    else if (!mem_we_n)       we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
    else                      we_low_cnt <= '0;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe && mem_we_n)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R3
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R4
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= 8'(WR_CYC))); // R5
  AST_WE_ENDS_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && !(&mem_be_n)
                         && $stable(mem_addr) && $stable(mem_dq_out))); // R6
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n)); // R7
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> !req_ready); // R8

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WR_CYC(WR_CYC)
) i_sram_ctrl_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  // R9: cycle counts from the rounding rule at a 4 ns clock
  localparam int CLK = 4;
  localparam int RD  = (10 + CLK - 1) / CLK;                 // 3
  localparam int WR  = (8 + CLK - 1) / CLK;                  // 2
  localparam int TA  = (5 + CLK - 1) / CLK;                  // 2

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [15:0] mem_model [0:255];
  logic [15:0] shadow    [0:255];

  always #2 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Memory model: disabled lanes return junk so masking is visible.
  logic [15:0] rd_word;
  assign rd_word   = mem_model[mem_addr[7:0]];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n)
                   ? {(!mem_be_n[1]) ? rd_word[15:8] : 8'hA5,
                      (!mem_be_n[0]) ? rd_word[7:0]  : 8'h5A}
                   : 16'hDEAD;

  always @(posedge mem_we_n) begin
    if (!rst && !mem_ce_n && mem_dq_oe) begin
      if (!mem_be_n[0]) mem_model[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_be_n[1]) mem_model[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic chk_idle_pins(input string req);
    chk(mem_ce_n === 1'b1, req, {31'd0, mem_ce_n}, 32'd1);
    chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, req, {30'd0, mem_we_n, mem_oe_n}, 32'd3);
    chk(mem_be_n === 2'b11, req, {30'd0, mem_be_n}, 32'd3);
    chk(mem_dq_oe === 1'b0, req, {31'd0, mem_dq_oe}, 32'd0);
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // One transaction, checked at every falling edge from acceptance on.
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit junk);
    int total;
    logic [15:0] exp_rd;
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    exp_rd = shadow[a[7:0]] & lane_mask(m);
    total = (m == 2'b00) ? 1 : (wr ? WR + 1 + TA : RD + TA);
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j == 0) begin
        if (junk) begin
          // R11: conflicting request held while busy
          req_addr = ~a; req_wdata = ~d; req_mask = ~m; req_write = ~wr;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (j == total) begin
        chk(req_ready === 1'b1, "R2 ready returns", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid === 1'b0, "R11 no extra response", {31'd0, rsp_valid}, 32'd0);
        chk_idle_pins("R1 idle after sequence");
        req_valid = 1'b0;
      end else begin
        chk(req_ready === 1'b0, "R2 busy", {31'd0, req_ready}, 32'd0);
        if (m == 2'b00) begin
          chk_idle_pins("R10 no pin toggles");
          chk(rsp_valid === !wr, "R10 nop response", {31'd0, rsp_valid}, {31'd0, !wr});
          if (!wr) chk(rsp_rdata === 16'h0, "R10 nop data", {16'd0, rsp_rdata}, 32'd0);
        end else if (!wr) begin
          if (j < RD) begin
            chk(mem_ce_n === 0 && mem_oe_n === 0 && mem_we_n === 1, "R3 read strobes",
                {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd1);
            chk(mem_be_n === ~m, "R3 read lanes", {30'd0, mem_be_n}, {30'd0, ~m});
            chk(mem_addr === a, "R11 R3 read address held", {16'd0, mem_addr}, {16'd0, a});
            chk(mem_dq_oe === 1'b0, "R7 no drive in read", {31'd0, mem_dq_oe}, 32'd0);
            chk(rsp_valid === 1'b0, "R4 no early valid", {31'd0, rsp_valid}, 32'd0);
          end else if (j == RD) begin
            chk(rsp_valid === 1'b1, "R4 valid pulse", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_rdata === exp_rd, "R4 read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
            chk_idle_pins("R8 turnaround after read");
          end else begin
            chk(rsp_valid === 1'b0, "R4 single pulse", {31'd0, rsp_valid}, 32'd0);
            chk_idle_pins("R8 turnaround after read");
          end
        end else begin
          chk(rsp_valid === 1'b0, "R11 no response on write", {31'd0, rsp_valid}, 32'd0);
          if (j < WR) begin
            chk(mem_ce_n === 0 && mem_we_n === 0 && mem_oe_n === 1, "R5 write strobes",
                {29'd0, mem_ce_n, mem_we_n, mem_oe_n}, 32'd1);
            chk(mem_be_n === ~m, "R5 write lanes", {30'd0, mem_be_n}, {30'd0, ~m});
            chk(mem_dq_out === d && mem_dq_oe === 1, "R5 write data", {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, d});
            chk(mem_addr === a, "R11 R5 write address held", {16'd0, mem_addr}, {16'd0, a});
          end else if (j == WR) begin
            chk(mem_we_n === 1 && mem_ce_n === 0, "R6 we rises first", {30'd0, mem_we_n, mem_ce_n}, 32'd2);
            chk(mem_be_n === ~m && mem_addr === a, "R6 lanes and address held",
                {14'd0, mem_be_n, mem_addr}, {14'd0, ~m, a});
            chk(mem_dq_out === d && mem_dq_oe === 1, "R6 data held", {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, d});
          end else begin
            chk_idle_pins("R6 R8 release and turnaround");
          end
        end
      end
    end
    if (wr) shadow[a[7:0]] = (shadow[a[7:0]] & ~lane_mask(m)) | (d & lane_mask(m));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 16'(i * 16'h0101 ^ 16'h3C3C);
      shadow[i]    = 16'(i * 16'h0101 ^ 16'h3C3C);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
    chk_idle_pins("R1 reset pins");

    // R9: counts shown at defaults through the timed windows in every access
    // Writes: every mask on sixteen addresses.
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        access(1'b1, 16'(a * 16'h1111), 16'((a * 16'h3C5A) ^ (m * 16'h1357) ^ 16'h1234),
               2'(m), (a + m) % 3 == 0);
      end
    end
    // Reads: every mask on the same addresses, back to back.
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        access(1'b0, 16'(a * 16'h1111), 16'h0, 2'(m), (a + m) % 2 == 0);
      end
    end
    // Alternating write and read on one word (turnaround both ways).
    for (int k = 0; k < 8; k++) begin
      access(1'b1, 16'h00F0, 16'(k * 16'h2B3D), 2'(k % 3 + 1), 1'b0);
      access(1'b0, 16'h00F0, 16'h0, 2'b11, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule